// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 8-bit channel samples between serial time-division-multiplexed lines. Four serial input lines and four serial output lines run at one bit per clock. A frame has 32 channel slots of 8 bits each, and a single-cycle frame pulse marks where a frame begins. Every byte that arrives is turned into parallel form and stored in a data memory at the location for its line and channel.

For each output slot, a host-programmed connection entry decides what is sent. The entry has two parts. The low part is an 8-bit value. The high part holds two flags: message select and line drive. When message select is clear, the low part names an input line and channel, and the stored byte from that location is sent (a switched connection). When message select is set, the low byte itself is sent, and it repeats in every frame until the host changes it. When line drive is clear, the output stays high for the whole slot.

A host programs the connection entries through a plain write port. The low part and the high part each have their own write strobe.

Top module: `tsi_switch`

## Requirements
- R1: After reset every connection entry is cleared, so every output line stays at 1.
- R2: The cycle in which `fp_i` is high is bit 7 (the MSB) of channel 0 on every input and every output line. The bits of a slot then follow MSB first, one per clock, and a new slot starts every 8 cycles.
- R3: The connection address `cm_addr` is {output line[6:5], channel[4:0]}. With high part {msg=0, drive=1} (high bit 1 = message select, bit 0 = drive), the output slot carries the stored byte of input line low[6:5], channel low[4:0].
- R4: In a switched slot, the byte sent is the most recent byte of the source channel whose input slot ended at least one whole slot before the output slot begins. Examples: source channel c-2 gives the same frame; source channel c-1 gives the previous frame; output channel 0 from input channel 31 gives the frame two back.
- R5: With high part {msg=1, drive=1}, the low byte is sent unchanged in that slot in every frame.
- R6: With the drive bit (bit 0) clear, the output line is 1 for all 8 bits of that slot, whatever the message bit and low byte hold.
- R7: `cm_lo_we` writes only the low part and `cm_hi_we` writes only the high part of the addressed entry. A write reaches the line from the next frame onward.
- R8: With no frame pulse, the internal slot counter keeps running. Frames keep repeating every 256 cycles with the last alignment.
- R9: Writes to the data memory and reads from it fall in different bit phases of a slot, so they never collide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during channel 0 bit 7 |
| st_in | input | 4 | Serial input lines, one bit per line |
| st_out | output | 4 | Serial output lines, one bit per line |
| cm_lo_we | input | 1 | Write strobe for the low part of a connection entry |
| cm_hi_we | input | 1 | Write strobe for the high part of a connection entry |
| cm_addr | input | 7 | Connection entry address {output line, channel} |
| cm_lo_data | input | 8 | Low part: source {line, channel} or message byte |
| cm_hi_data | input | 2 | High part: bit 1 message select, bit 0 line drive |

## Verification
Random input bytes fill every channel of every frame, and each output slot is compared with a model that applies the slot-age rule across frame boundaries. A random mix of switched, message and undriven entries exercises all three sources. Directed entries pin down the source channel c-2, c-1 and channel-31-into-channel-0 cases, which tell same-frame, previous-frame and two-frame-old data apart. Mid-run writes to only the high part, and then to only the low part, show that each strobe leaves the other part untouched. Dropping the frame pulse for the last frames shows whether the counter keeps the alignment on its own.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned DEF_LINES    = 4;
  localparam int unsigned DEF_CHANNELS = 32;
  localparam int unsigned DEF_BYTE_W   = 8;

  typedef enum logic {
    SRC_SWITCHED = 1'b0,
    SRC_MESSAGE  = 1'b1
  } slot_src_e;

  // High part of a connection entry: bit 1 selects the source, bit 0 drives the line.
  typedef struct packed {
    slot_src_e src;
    logic      drive;
  } cm_high_t;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int unsigned NUM_CH = tsi_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W = tsi_pkg::DEF_BYTE_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned PH_W  = $clog2(BYTE_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_i,
  output logic [CH_W-1:0] chan_o,
  output logic [PH_W-1:0] phase_o
);
  localparam int unsigned CNT_W = CH_W + PH_W;

  logic [CNT_W-1:0] cnt_q, cnt_cur, cnt_d;

  // The frame pulse forces the current cycle to slot 0, phase 0.
  always_comb begin
    cnt_cur = fp_i ? '0 : cnt_q;
    cnt_d   = cnt_cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign chan_o  = cnt_cur[CNT_W-1:PH_W];
  assign phase_o = cnt_cur[PH_W-1:0];

  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int unsigned NUM_LN  = tsi_pkg::DEF_LINES,
  parameter int unsigned NUM_CH  = tsi_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W  = tsi_pkg::DEF_BYTE_W,
  localparam int unsigned LN_W   = $clog2(NUM_LN),
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned PH_W   = $clog2(BYTE_W),
  localparam int unsigned ADDR_W = LN_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LN-1:0] st_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(BYTE_W - 1);
  localparam logic [PH_W-1:0] WR_END  = PH_W'(NUM_LN);

  logic [NUM_LN-1:0][BYTE_W-2:0] sh_q, sh_d;
  logic [NUM_LN-1:0][BYTE_W-1:0] hold_q, hold_d, full_byte;
  logic [CH_W-1:0]               hold_ch_q, hold_ch_d;
  logic                          hold_vld_q, hold_vld_d;
  logic                          capture;
  logic [LN_W-1:0]               wr_line;

  assign capture = (phase_i == LAST_PH);

  for (genvar s = 0; s < NUM_LN; s++) begin : g_deser
    always_comb begin
      full_byte[s] = {sh_q[s], st_i[s]};
      sh_d[s]      = full_byte[s][BYTE_W-2:0];
      hold_d[s]    = capture ? full_byte[s] : hold_q[s];
    end
  end

  always_comb begin
    hold_ch_d  = capture ? chan_i : hold_ch_q;
    hold_vld_d = hold_vld_q | capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      hold_q     <= '0;
      hold_ch_q  <= '0;
      hold_vld_q <= 1'b0;
    end else begin
      sh_q       <= sh_d;
      hold_q     <= hold_d;
      hold_ch_q  <= hold_ch_d;
      hold_vld_q <= hold_vld_d;
    end
  end

  // Held bytes are written one line per phase in the first phases of the next slot.
  assign wr_line   = phase_i[LN_W-1:0];
  assign wr_en_o   = hold_vld_q && (phase_i < WR_END);
  assign wr_addr_o = {wr_line, hold_ch_q};
  assign wr_data_o = hold_q[wr_line];

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != LAST_PH) |=> $stable(hold_q));
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
  parameter int unsigned NUM_LN  = tsi_pkg::DEF_LINES,
  parameter int unsigned NUM_CH  = tsi_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W  = tsi_pkg::DEF_BYTE_W,
  localparam int unsigned DEPTH  = NUM_LN * NUM_CH,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem #(
  parameter int unsigned NUM_LN  = tsi_pkg::DEF_LINES,
  parameter int unsigned NUM_CH  = tsi_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W  = tsi_pkg::DEF_BYTE_W,
  localparam int unsigned DEPTH  = NUM_LN * NUM_CH,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic [ADDR_W-1:0]  waddr_i,
  input  logic [BYTE_W-1:0]  lo_wdata_i,
  input  tsi_pkg::cm_high_t  hi_wdata_i,
  input  logic [ADDR_W-1:0]  raddr_i,
  output logic [BYTE_W-1:0]  lo_rdata_o,
  output tsi_pkg::cm_high_t  hi_rdata_o
);
  logic [BYTE_W-1:0] lo_q [DEPTH];
  tsi_pkg::cm_high_t hi_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end
    end else begin
      if (lo_we_i) lo_q[waddr_i] <= lo_wdata_i;
      if (hi_we_i) hi_q[waddr_i] <= hi_wdata_i;
    end
  end

  assign lo_rdata_o = lo_q[raddr_i];
  assign hi_rdata_o = hi_q[raddr_i];

  assert_low_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we_i |=> (lo_q[$past(waddr_i)] == $past(lo_wdata_i)));
  assert_low_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we_i && !lo_we_i) |=> (lo_q[$past(waddr_i)] == $past(lo_q[waddr_i])));
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
  parameter int unsigned NUM_LN  = tsi_pkg::DEF_LINES,
  parameter int unsigned NUM_CH  = tsi_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W  = tsi_pkg::DEF_BYTE_W,
  localparam int unsigned LN_W   = $clog2(NUM_LN),
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned PH_W   = $clog2(BYTE_W),
  localparam int unsigned ADDR_W = LN_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic [ADDR_W-1:0] cm_addr_o,
  input  logic [BYTE_W-1:0] cm_lo_i,
  input  tsi_pkg::cm_high_t cm_hi_i,
  output logic              dm_re_o,
  output logic [ADDR_W-1:0] dm_addr_o,
  input  logic [BYTE_W-1:0] dm_rdata_i,
  output logic [NUM_LN-1:0] st_o
);
  localparam logic [PH_W-1:0] LAST_PH    = PH_W'(BYTE_W - 1);
  localparam logic [PH_W-1:0] FETCH_BASE = PH_W'(BYTE_W - NUM_LN);

  logic              fetch_act;
  logic [PH_W-1:0]   fetch_off;
  logic [LN_W-1:0]   fetch_ln;
  logic [CH_W-1:0]   next_ch;
  logic [BYTE_W-1:0] fetch_byte;
  logic              load;

  logic [NUM_LN-1:0][BYTE_W-1:0] nxt_q, nxt_d, sh_q, sh_d, load_byte;
  logic [NUM_LN-1:0]             nxt_drv_q, nxt_drv_d, drv_q, drv_d, load_drv, fetch_hit;

  // Fetch for the following slot, one output line per phase in the last phases.
  always_comb begin
    fetch_act  = (phase_i >= FETCH_BASE);
    fetch_off  = phase_i - FETCH_BASE;
    fetch_ln   = fetch_off[LN_W-1:0];
    next_ch    = chan_i + 1'b1;
    load       = (phase_i == LAST_PH);
    fetch_byte = (cm_hi_i.src == tsi_pkg::SRC_MESSAGE) ? cm_lo_i : dm_rdata_i;
  end

  assign cm_addr_o = {fetch_ln, next_ch};
  assign dm_re_o   = fetch_act && (cm_hi_i.src == tsi_pkg::SRC_SWITCHED);
  assign dm_addr_o = cm_lo_i[ADDR_W-1:0];

  for (genvar o = 0; o < NUM_LN; o++) begin : g_ser
    always_comb begin
      fetch_hit[o] = fetch_act && (fetch_ln == LN_W'(o));
      nxt_d[o]     = fetch_hit[o] ? fetch_byte : nxt_q[o];
      nxt_drv_d[o] = fetch_hit[o] ? cm_hi_i.drive : nxt_drv_q[o];
      load_byte[o] = nxt_d[o];
      load_drv[o]  = nxt_drv_d[o];
      sh_d[o]      = load ? load_byte[o] : {sh_q[o][BYTE_W-2:0], 1'b1};
      drv_d[o]     = load ? load_drv[o] : drv_q[o];
    end

    assign st_o[o] = drv_q[o] ? sh_q[o][BYTE_W-1] : 1'b1;

    assert_drive_per_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i != LAST_PH) |=> $stable(drv_q[o]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q     <= '1;
      nxt_drv_q <= '0;
      sh_q      <= '1;
      drv_q     <= '0;
    end else begin
      nxt_q     <= nxt_d;
      nxt_drv_q <= nxt_drv_d;
      sh_q      <= sh_d;
      drv_q     <= drv_d;
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int unsigned NUM_LN  = tsi_pkg::DEF_LINES,
  parameter int unsigned NUM_CH  = tsi_pkg::DEF_CHANNELS,
  parameter int unsigned BYTE_W  = tsi_pkg::DEF_BYTE_W,
  localparam int unsigned ADDR_W = $clog2(NUM_LN) + $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_i,
  input  logic [NUM_LN-1:0] st_in,
  output logic [NUM_LN-1:0] st_out,
  input  logic              cm_lo_we,
  input  logic              cm_hi_we,
  input  logic [ADDR_W-1:0] cm_addr,
  input  logic [BYTE_W-1:0] cm_lo_data,
  input  logic [1:0]        cm_hi_data
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam int unsigned PH_W = $clog2(BYTE_W);

  logic rst_meta_q, rst_sync_q;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [CH_W-1:0]   chan;
  logic [PH_W-1:0]   phase;
  logic              rx_we, tx_re;
  logic [ADDR_W-1:0] rx_addr, tx_addr, dm_addr, cm_raddr;
  logic [BYTE_W-1:0] rx_data, dm_rdata, cm_lo;
  tsi_pkg::cm_high_t cm_hi;

  tsi_timing #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_timing (
    .clk(clk), .rst_n(rst_sync_q), .fp_i(fp_i), .chan_o(chan), .phase_o(phase));

  tsi_rx #(.NUM_LN(NUM_LN), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_q), .st_i(st_in), .chan_i(chan), .phase_i(phase),
    .wr_en_o(rx_we), .wr_addr_o(rx_addr), .wr_data_o(rx_data));

  assign dm_addr = rx_we ? rx_addr : tx_addr;

  tsi_dmem #(.NUM_LN(NUM_LN), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dmem (
    .clk(clk), .we_i(rx_we), .addr_i(dm_addr), .wdata_i(rx_data), .rdata_o(dm_rdata));

  tsi_cmem #(.NUM_LN(NUM_LN), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_cmem (
    .clk(clk), .rst_n(rst_sync_q), .lo_we_i(cm_lo_we), .hi_we_i(cm_hi_we),
    .waddr_i(cm_addr), .lo_wdata_i(cm_lo_data), .hi_wdata_i(tsi_pkg::cm_high_t'(cm_hi_data)),
    .raddr_i(cm_raddr), .lo_rdata_o(cm_lo), .hi_rdata_o(cm_hi));

  tsi_tx #(.NUM_LN(NUM_LN), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_sync_q), .chan_i(chan), .phase_i(phase),
    .cm_addr_o(cm_raddr), .cm_lo_i(cm_lo), .cm_hi_i(cm_hi),
    .dm_re_o(tx_re), .dm_addr_o(tx_addr), .dm_rdata_i(dm_rdata), .st_o(st_out));

  assert_mem_slots_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(rx_we && tx_re));
endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int NF      = 16;
  localparam int FP_LAST = 10;
  localparam int W_HI_G  = 6 * 32 + 10;
  localparam int W_LO_G  = 8 * 32 + 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fp_i;
  logic [3:0] st_in, st_out;
  logic       cm_lo_we, cm_hi_we;
  logic [6:0] cm_addr;
  logic [7:0] cm_lo_data;
  logic [1:0] cm_hi_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] in_hist [4][NF*32];
  logic [7:0] cfg_lo  [128];
  logic [1:0] cfg_hi  [128];
  logic [7:0] cap     [4];

  always #5 clk = ~clk;

  tsi_switch i_tsi_switch (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .st_in(st_in), .st_out(st_out),
    .cm_lo_we(cm_lo_we), .cm_hi_we(cm_hi_we), .cm_addr(cm_addr),
    .cm_lo_data(cm_lo_data), .cm_hi_data(cm_hi_data));

  // Source byte by the slot-age rule: newest input slot ending at least one slot earlier.
  function automatic logic [7:0] exp_byte(int a, int gout);
    int s, x, d;
    logic [7:0] lo;
    lo = cfg_lo[a];
    if (!cfg_hi[a][0]) return 8'hFF;
    if (cfg_hi[a][1]) return lo;
    s = int'(lo[6:5]);
    x = int'(lo[4:0]);
    d = (((gout - 2 - x) % 32) + 32) % 32;
    return in_hist[s][gout - 2 - d];
  endfunction

  function automatic string tag_of(int a, int fr);
    if (fr == 2) return "R2";
    if (fr >= FP_LAST) return "R8";
    if ((a == 37 && fr > 6) || (a == 95 && fr > 8)) return "R7";
    if (a == 0 || a == 1 || a == 37 || a == 38) return "R4";
    if (!cfg_hi[a][0]) return "R6";
    if (cfg_hi[a][1]) return "R5";
    return "R3/R9";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic host_wr(int a, logic [7:0] lo, logic [1:0] hi);
    @(negedge clk);
    cm_addr = 7'(a); cm_lo_data = lo; cm_hi_data = hi;
    cm_lo_we = 1'b1; cm_hi_we = 1'b1;
    cfg_lo[a] = lo; cfg_hi[a] = hi;
    @(negedge clk);
    cm_lo_we = 1'b0; cm_hi_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r;
    logic [7:0] lo;
    logic [1:0] hi;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; fp_i = 1'b0; st_in = 4'hF;
    cm_lo_we = 1'b0; cm_hi_we = 1'b0; cm_addr = '0; cm_lo_data = '0; cm_hi_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {4'h0, st_out}, 8'h0F);
    repeat (9) @(negedge clk);
    check("R1", {4'h0, st_out}, 8'h0F);

    for (int s = 0; s < 4; s++)
      for (int g = 0; g < NF * 32; g++) in_hist[s][g] = 8'($urandom);

    for (int a = 0; a < 128; a++) begin
      r  = int'($urandom % 10);
      lo = 8'($urandom);
      if (r < 6)      hi = 2'b01;
      else if (r < 8) hi = 2'b11;
      else            hi = {1'($urandom), 1'b0};
      host_wr(a, lo, hi);
    end
    host_wr(0,  8'h7F, 2'b01);   // out 0 ch 0  <- line 3 ch 31
    host_wr(1,  8'h7F, 2'b01);   // out 0 ch 1  <- line 3 ch 31
    host_wr(37, 8'h43, 2'b01);   // out 1 ch 5  <- line 2 ch 3
    host_wr(38, 8'h45, 2'b01);   // out 1 ch 6  <- line 2 ch 5
    host_wr(95, 8'hA5, 2'b11);   // out 2 ch 31 message
    host_wr(98, 8'h5A, 2'b10);   // out 3 ch 2  message but undriven
    host_wr(99, 8'h00, 2'b01);   // out 3 ch 3  <- line 0 ch 0

    repeat (37) @(negedge clk);  // counter runs unaligned before the first pulse

    for (int g = 0; g < NF * 32; g++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        fp_i = (g % 32 == 0) && (b == 0) && (g < FP_LAST * 32);
        for (int s = 0; s < 4; s++) st_in[s] = in_hist[s][g][7 - b];
        for (int o = 0; o < 4; o++) cap[o][7 - b] = st_out[o];
        if (g == W_HI_G && b == 0) begin
          cm_addr = 7'd37; cm_hi_data = 2'b11; cm_lo_data = 8'hEE; cm_hi_we = 1'b1;
          cfg_hi[37] = 2'b11;
        end else if (g == W_LO_G && b == 0) begin
          cm_addr = 7'd95; cm_lo_data = 8'h3C; cm_hi_data = 2'b00; cm_lo_we = 1'b1;
          cfg_lo[95] = 8'h3C;
        end else begin
          cm_hi_we = 1'b0; cm_lo_we = 1'b0;
        end
        if (b == 7 && g >= 64 && (g / 32) != 6 && (g / 32) != 8) begin
          for (int o = 0; o < 4; o++) begin
            int a;
            a = o * 32 + (g % 32);
            check(tag_of(a, g / 32), cap[o], exp_byte(a, g));
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule